// File: doc/BRIEF.md
# Set-Dueling Policy Selector

This block picks, at run time, which of two cache management policies (policy 0 or policy 1) each cache set applies. A small number of sampled sets is permanently tied to one policy or the other and acts as a running experiment. Every other set is a follower and copies whichever policy is currently losing fewer misses in the sampled sets.

The cache presents the set index of each access together with a valid strobe and a miss flag. The block returns a one-bit policy select for that index in the same cycle. Sets are classified by their index alone. A set belongs to the policy-0 sample when the upper half of its index equals the lower half. It belongs to the policy-1 sample when the upper half equals the bitwise inverse of the lower half. All remaining sets are followers. A single saturating counter weighs the misses of the two samples, and its top bit steers the followers. The block never stalls the cache: every presented access is accepted in the cycle it is valid, so no ready signal or back-pressure exists.

Top module: `set_duel_sel`

## Requirements
- R1: After reset the counter holds its midpoint (top bit 1, all other bits 0), so a follower set reads policy 1.
- R2: A set whose upper index half equals its lower index half always gets `pol_sel` = 0, whatever the counter value.
- R3: A set whose upper index half equals the bitwise inverse of its lower index half always gets `pol_sel` = 1, whatever the counter value.
- R4: A valid miss in a policy-0 sample set raises the counter by one.
- R5: A valid miss in a policy-1 sample set lowers the counter by one.
- R6: The counter stops at its maximum (all ones); further policy-0 sample misses leave it there.
- R7: The counter stops at zero; further policy-1 sample misses leave it there.
- R8: Hits in any set, misses in follower sets, and cycles with `acc_valid` low leave the counter unchanged.
- R9: A follower set gets `pol_sel` equal to the counter's top bit (0 selects policy 0, 1 selects policy 1).
- R10: `pol_sel` depends combinationally on the present index and the registered counter, so a counter update shows on the access in the cycle after the miss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_set | input | IDX_W | Set index of the access |
| acc_miss | input | 1 | The access missed in the cache |
| pol_sel | output | 1 | Policy to apply for `acc_set` (0 or 1) |

## Verification
Long directed runs of misses in one sample drive the counter to each rail and back. The exact number of opposite misses needed to flip the follower select tells a saturating counter from one that wraps or miscounts. Hits and follower misses are issued with the counter sitting exactly at its midpoint, where a single wrong step would flip the follower select. Random streams biased toward the two sample groups then mix all three set kinds, which separates a correct classification of the index from one that confuses the inverse match with the plain match or lets sample sets follow the counter.

// File: rtl/dp_pkg.sv
package dp_pkg;
  typedef enum logic [1:0] {
    KIND_FOLLOW = 2'd0,
    KIND_P0     = 2'd1,
    KIND_P1     = 2'd2
  } set_kind_e;
endpackage

// File: rtl/dp_set_classify.sv
module dp_set_classify
  import dp_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic [IDX_W-1:0] idx,
  output set_kind_e        kind
);
  localparam int HALF = IDX_W / 2;

  logic [HALF-1:0] hi_part;
  logic [HALF-1:0] lo_part;
  logic            is_p0;
  logic            is_p1;

  assign hi_part = idx[IDX_W-1 -: HALF];
  assign lo_part = idx[HALF-1:0];
  assign is_p0   = (hi_part == lo_part);
  assign is_p1   = (hi_part == ~lo_part);

  always_comb begin
    if (is_p0)      kind = KIND_P0;
    else if (is_p1) kind = KIND_P1;
    else            kind = KIND_FOLLOW;
  end
endmodule

// File: rtl/dp_sat_counter.sv
module dp_sat_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_up,
  input  logic             step_dn,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MIN = '0;
  localparam logic [CNT_W-1:0] CNT_MID = {1'b1, {(CNT_W-1){1'b0}}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (step_up && !step_dn && cnt_q != CNT_MAX)
      cnt_d = cnt_q + 1'b1;
    else if (step_dn && !step_up && cnt_q != CNT_MIN)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= CNT_MID;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/dp_policy_mux.sv
module dp_policy_mux
  import dp_pkg::*;
(
  input  set_kind_e kind,
  input  logic      leader_bit,
  output logic      pol
);
  always_comb begin
    unique case (kind)
      KIND_P0: pol = 1'b0;
      KIND_P1: pol = 1'b1;
      default: pol = leader_bit;
    endcase
  end
endmodule

// File: rtl/set_duel_sel.sv
module set_duel_sel
  import dp_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [IDX_W-1:0] acc_set,
  input  logic             acc_miss,
  output logic             pol_sel
);
  set_kind_e        kind;
  logic             miss_seen;
  logic             up_req;
  logic             dn_req;
  logic [CNT_W-1:0] cnt_q;

  dp_set_classify #(.IDX_W(IDX_W)) u_cls (
    .idx  (acc_set),
    .kind (kind)
  );

  assign miss_seen = acc_valid && acc_miss;
  assign up_req    = miss_seen && (kind == KIND_P0);
  assign dn_req    = miss_seen && (kind == KIND_P1);

  dp_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_up (up_req),
    .step_dn (dn_req),
    .cnt     (cnt_q)
  );

  dp_policy_mux u_mux (
    .kind       (kind),
    .leader_bit (cnt_q[CNT_W-1]),
    .pol        (pol_sel)
  );
endmodule

// File: rtl/dp_checker.sv
module dp_checker #(
  parameter int IDX_W = 10,
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic [IDX_W-1:0] acc_set,
  input logic             acc_miss,
  input logic             pol_sel,
  input logic [CNT_W-1:0] cnt
);
  localparam int HALF = IDX_W / 2;
  localparam logic [CNT_W-1:0] TOP = '1;
  localparam logic [CNT_W-1:0] MID = {1'b1, {(CNT_W-1){1'b0}}};

  logic c_p0, c_p1;
  assign c_p0 = (acc_set[IDX_W-1 -: HALF] == acc_set[HALF-1:0]);
  assign c_p1 = (acc_set[IDX_W-1 -: HALF] == ~acc_set[HALF-1:0]);

  p_reset_mid_r1: assert property (@(posedge clk) $rose(rst_n) |-> cnt == MID);
  p_p0_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n) c_p0 |-> !pol_sel);
  p_p1_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n) c_p1 |-> pol_sel);
  p_step_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_miss && c_p0 && cnt != TOP) |=> cnt == $past(cnt) + 1'b1);
  p_step_dn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_miss && c_p1 && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
  p_sat_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_miss && c_p0 && cnt == TOP) |=> cnt == TOP);
  p_sat_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_miss && c_p1 && cnt == '0) |=> cnt == '0);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_miss && (c_p0 || c_p1)) |=> $stable(cnt));
  p_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_p0 && !c_p1) |-> pol_sel == cnt[CNT_W-1]);
endmodule

bind set_duel_sel dp_checker #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_valid (acc_valid),
  .acc_set   (acc_set),
  .acc_miss  (acc_miss),
  .pol_sel   (pol_sel),
  .cnt       (cnt_q)
);

// File: tb/test_set_duel_sel.sv
`timescale 1ns/1ps
module test_set_duel_sel;
  localparam int IDX_W = 10;
  localparam int CNT_W = 10;
  localparam int HALF  = IDX_W / 2;
  localparam int CMAX  = (1 << CNT_W) - 1;
  localparam int CMID  = 1 << (CNT_W - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0;
  logic [IDX_W-1:0] acc_set = '0;
  logic acc_miss = 1'b0;
  logic pol_sel;

  int n_vec = 0;
  int n_bad = 0;
  int model = CMID;

  always #2.5 clk = ~clk;

  set_duel_sel #(.IDX_W(IDX_W), .CNT_W(CNT_W)) i_set_duel_sel (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid),
    .acc_set(acc_set), .acc_miss(acc_miss), .pol_sel(pol_sel)
  );

  // 1 = policy-0 sample, 2 = policy-1 sample, 0 = follower
  function automatic int kind_of(logic [IDX_W-1:0] s);
    logic [HALF-1:0] h, l;
    h = s[IDX_W-1 -: HALF];
    l = s[HALF-1:0];
    if (h == l) return 1;
    if (h == ~l) return 2;
    return 0;
  endfunction

  function automatic logic exp_pol(logic [IDX_W-1:0] s, int m);
    int k;
    k = kind_of(s);
    if (k == 1) return 1'b0;
    if (k == 2) return 1'b1;
    return (m >= CMID);
  endfunction

  function automatic logic [IDX_W-1:0] mk_set(int k, logic [HALF-1:0] l, logic [IDX_W-1:0] any);
    if (k == 1) return {l, l};
    if (k == 2) return {~l, l};
    return any;
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: pol_sel=%0b expected %0b (set=%0h model=%0d)", tag, act, exp, acc_set, model);
    end
  endtask

  // Drive at the falling edge, check combinational output, then commit at the rising edge.
  task automatic apply(input logic v, input logic [IDX_W-1:0] s, input logic m);
    int k;
    @(negedge clk);
    acc_valid = v; acc_set = s; acc_miss = m;
    #1;
    k = kind_of(s);
    check(pol_sel, exp_pol(s, model),
          k == 1 ? "R2" : (k == 2 ? "R3" : "R9/R10"));
    @(posedge clk);
    if (v && m) begin
      if (k == 1 && model < CMAX) model++;
      else if (k == 2 && model > 0) model--;
    end
  endtask

  localparam logic [IDX_W-1:0] FOL = {5'b00001, 5'b00010};
  localparam logic [IDX_W-1:0] SP0 = {5'b01101, 5'b01101};
  localparam logic [IDX_W-1:0] SP1 = {5'b10010, 5'b01101};

  task automatic probe(input logic exp, input string tag);
    @(negedge clk);
    acc_valid = 1'b0; acc_set = FOL; acc_miss = 1'b0;
    #1;
    check(pol_sel, exp, tag);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    model = CMID;

    // R1: midpoint after reset -> follower reads policy 1
    probe(1'b1, "R1");

    // R8: hits and follower misses at the midpoint must not move the counter
    for (int i = 0; i < 8; i++) apply(1'b1, SP0, 1'b0);
    for (int i = 0; i < 8; i++) apply(1'b1, SP1, 1'b0);
    for (int i = 0; i < 8; i++) apply(1'b1, FOL, 1'b1);
    for (int i = 0; i < 8; i++) apply(1'b0, SP1, 1'b1);
    probe(1'b1, "R8");

    // R5 + R10: one policy-1 sample miss flips followers on the next access
    apply(1'b1, SP1, 1'b1);
    probe(1'b0, "R5");
    // R4: one policy-0 sample miss returns to the midpoint
    apply(1'b1, SP0, 1'b1);
    probe(1'b1, "R4");

    // R6: drive to the top rail and beyond, then count back down
    for (int i = 0; i < CMAX; i++) apply(1'b1, SP0, 1'b1);
    probe(1'b1, "R6");
    for (int i = 0; i < CMAX - CMID; i++) apply(1'b1, SP1, 1'b1);
    probe(1'b1, "R6");
    apply(1'b1, SP1, 1'b1);
    probe(1'b0, "R6");

    // R7: drive to zero and beyond, then count back up
    for (int i = 0; i < CMAX; i++) apply(1'b1, SP1, 1'b1);
    probe(1'b0, "R7");
    apply(1'b1, SP0, 1'b0);
    for (int i = 0; i < CMID - 1; i++) apply(1'b1, SP0, 1'b1);
    probe(1'b0, "R7");
    apply(1'b1, SP0, 1'b1);
    probe(1'b1, "R7");

    // Dedicated sets ignore the counter at both rails (R2, R3)
    for (int i = 0; i < CMID + 4; i++) apply(1'b1, SP1, 1'b1);
    apply(1'b1, SP0, 1'b0);
    apply(1'b1, SP1, 1'b0);

    // Random mix biased toward the sample groups
    for (int i = 0; i < 4000; i++) begin
      int k;
      logic [HALF-1:0] lo;
      logic [IDX_W-1:0] any;
      k  = $urandom % 5;
      lo = HALF'($urandom);
      any = IDX_W'($urandom);
      apply(($urandom % 8) != 0, mk_set(k > 2 ? 0 : k, lo, any), ($urandom % 3) != 0);
    end

    finish_run();
  end
endmodule